// File: doc/BRIEF.md
# Low-Power Clock-Enable Divider with Fast Wake

This block produces the system clock enable for a core that runs from a single oscillator clock. In full-speed operation the enable is high on every oscillator cycle. When software sets the low-power mode bit, the enable drops to one pulse every 2**DIV_WIDTH oscillator cycles (256 by default). Everything clocked by the enable keeps working as normal, only more slowly. Clearing the bit returns the block to full rate on the next cycle.

Two safeguards protect data. First, a request to enter low-power mode is dropped without effect while any serial port reports activity or any external interrupt is pending. Second, a separate wake-enable bit can be set. While it is set, a new serial transfer or a newly pending external interrupt makes the hardware clear the mode bit, so the core returns to full speed without software acting. Both mode bits can be read back from dedicated outputs.

Top module: `pm_clkdiv_top`

## Requirements
- R1: While mode_bit is 0, sys_ce is 1 on every oscillator cycle.
- R2: If mode_bit first reads 1 in cycle c, sys_ce is 0 in cycles c to c+255 and 1 in cycle c+256. After that it pulses for one cycle every 256 cycles for as long as the mode stays set (period 2**DIV_WIDTH).
- R3: In the first cycle in which mode_bit reads 0 after being 1, sys_ce is already 1, without waiting for the divide counter to wrap.
- R4: A cycle with wr_mode_en=1 loads wr_mode_val into mode_bit, and the new value is visible in the next cycle. Writing 1 while mode_bit is already 1 does not restart the pulse spacing.
- R5: A write of 1 is ignored, and mode_bit stays 0, if any bit of serial_busy is 1 in the write cycle.
- R6: A write of 1 is ignored, and mode_bit stays 0, if any bit of extint_pend is 1 in the write cycle.
- R7: Suppose swb_bit=1 and mode_bit=1, and some bit of serial_busy or extint_pend is 1 in a cycle after being 0 in the cycle before. Then mode_bit reads 0 in the next cycle. If swb_bit=0, the same transition leaves mode_bit at 1.
- R8: A cycle with wr_swb_en=1 loads wr_swb_val into swb_bit, visible in the next cycle. A wake event never changes swb_bit.
- R9: While rst is 1, and in the first cycle after it, mode_bit=0, swb_bit=0 and sys_ce=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode_en | input | 1 | Software write strobe for the low-power mode bit |
| wr_mode_val | input | 1 | Value written to the mode bit |
| wr_swb_en | input | 1 | Software write strobe for the wake-enable bit |
| wr_swb_val | input | 1 | Value written to the wake-enable bit |
| serial_busy | input | NUM_SERIAL | One activity flag per serial port (transmit or receive) |
| extint_pend | input | NUM_EXTINT | One pending flag per external interrupt |
| sys_ce | output | 1 | Registered system clock enable |
| mode_bit | output | 1 | Current low-power mode bit |
| swb_bit | output | 1 | Current wake-enable bit |

## Verification
Every register result in this block is due one clock after the cycle that causes it. That includes a write, a blocked write and a wake transition, and sys_ce follows the new mode bit in that same cycle. The only longer window is the 256-cycle gap after entry, which the bench measures by counting enable pulses. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and both the model and the outputs are compared on the next falling edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // Classification of each oscillator cycle for the divider.
  typedef enum logic [1:0] {
    DIV_FULL  = 2'd0,  // mode off next cycle: enable every cycle
    DIV_ENTER = 2'd1,  // mode turning on: restart spacing
    DIV_SLOW  = 2'd2   // mode staying on: count towards the next pulse
  } div_step_e;
endpackage

// File: rtl/pm_activity.sv
// Level and rising-transition summary for a group of activity flags.
module pm_activity #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic             any_o,
  output logic             rise_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise_bits;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign rise_bits[gi] = lvl_i[gi] & ~prev_q[gi];
    end
  endgenerate

  assign any_o  = |lvl_i;
  assign rise_o = |rise_bits;

  // A rising flag is always also an active flag.
  assert_rise_is_active_R7: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> any_o);
endmodule

// File: rtl/pm_mode_ctrl.sv
// Holds the low-power mode bit and the wake-enable bit.
module pm_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_mode_en,
  input  logic wr_mode_val,
  input  logic wr_swb_en,
  input  logic wr_swb_val,
  input  logic block_i,
  input  logic wake_i,
  output logic mode_d_o,
  output logic mode_q_o,
  output logic swb_q_o
);
  logic mode_q;
  logic swb_q;
  logic mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode_en) begin
      if (!wr_mode_val)  mode_d = 1'b0;
      else if (!block_i) mode_d = 1'b1;
    end
    if (swb_q && mode_q && wake_i) mode_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      swb_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (wr_swb_en) swb_q <= wr_swb_val;
    end
  end

  assign mode_d_o = mode_d;
  assign mode_q_o = mode_q;
  assign swb_q_o  = swb_q;

  assert_guarded_set_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_mode_en && wr_mode_val && !mode_q && block_i) |=> !mode_q);

  assert_switchback_R7: assert property (@(posedge clk) disable iff (rst)
    (swb_q && mode_q && wake_i) |=> !mode_q);

  assert_swb_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_swb_en |=> $stable(swb_q));

  assert_clear_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_mode_en && !wr_mode_val) |=> !mode_q);
endmodule

// File: rtl/pm_divider.sv
// Produces the registered system clock enable.
module pm_divider
  import pm_pkg::*;
#(
  parameter int DIV_WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_d_i,
  input  logic mode_q_i,
  output logic ce_o
);
  localparam logic [DIV_WIDTH-1:0] CNT_MAX = {DIV_WIDTH{1'b1}};

  logic [DIV_WIDTH-1:0] cnt_q;
  logic                 ce_q;
  div_step_e            step;

  always_comb begin
    if (!mode_d_i)     step = DIV_FULL;
    else if (!mode_q_i) step = DIV_ENTER;
    else               step = DIV_SLOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ce_q  <= 1'b1;
    end else begin
      case (step)
        DIV_ENTER: begin
          cnt_q <= '0;
          ce_q  <= 1'b0;
        end
        DIV_SLOW: begin
          cnt_q <= cnt_q + 1'b1;
          ce_q  <= (cnt_q == CNT_MAX);
        end
        default: begin
          cnt_q <= '0;
          ce_q  <= 1'b1;
        end
      endcase
    end
  end

  assign ce_o = ce_q;

  assert_full_rate_R1: assert property (@(posedge clk) disable iff (rst)
    !mode_q_i |-> ce_q);

  assert_entry_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q_i) |-> !ce_q);

  assert_fast_exit_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q_i) |-> ce_q);
endmodule

// File: rtl/pm_clkdiv_top.sv
module pm_clkdiv_top #(
  parameter int DIV_WIDTH  = 8,
  parameter int NUM_SERIAL = 2,
  parameter int NUM_EXTINT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_mode_en,
  input  logic                  wr_mode_val,
  input  logic                  wr_swb_en,
  input  logic                  wr_swb_val,
  input  logic [NUM_SERIAL-1:0] serial_busy,
  input  logic [NUM_EXTINT-1:0] extint_pend,
  output logic                  sys_ce,
  output logic                  mode_bit,
  output logic                  swb_bit
);
  logic ser_any, ser_rise;
  logic ext_any, ext_rise;
  logic mode_d, mode_q, swb_q;

  pm_activity #(.WIDTH(NUM_SERIAL)) u_ser_act (
    .clk(clk), .rst(rst), .lvl_i(serial_busy),
    .any_o(ser_any), .rise_o(ser_rise)
  );

  pm_activity #(.WIDTH(NUM_EXTINT)) u_ext_act (
    .clk(clk), .rst(rst), .lvl_i(extint_pend),
    .any_o(ext_any), .rise_o(ext_rise)
  );

  pm_mode_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .wr_mode_en(wr_mode_en), .wr_mode_val(wr_mode_val),
    .wr_swb_en(wr_swb_en), .wr_swb_val(wr_swb_val),
    .block_i(ser_any | ext_any), .wake_i(ser_rise | ext_rise),
    .mode_d_o(mode_d), .mode_q_o(mode_q), .swb_q_o(swb_q)
  );

  pm_divider #(.DIV_WIDTH(DIV_WIDTH)) u_div (
    .clk(clk), .rst(rst), .mode_d_i(mode_d), .mode_q_i(mode_q), .ce_o(sys_ce)
  );

  assign mode_bit = mode_q;
  assign swb_bit  = swb_q;

  assert_reset_state_R9: assert property (@(posedge clk)
    $past(rst) |-> (!mode_bit && !swb_bit && sys_ce));
endmodule

// File: tb/pm_clkdiv_top_tb.sv
`timescale 1ns/1ps
module pm_clkdiv_top_tb;
  localparam int NS = 2;
  localparam int NE = 4;
  localparam int PERIOD = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_mode_en = 1'b0, wr_mode_val = 1'b0;
  logic wr_swb_en = 1'b0, wr_swb_val = 1'b0;
  logic [NS-1:0] serial_busy = '0;
  logic [NE-1:0] extint_pend = '0;
  logic sys_ce, mode_bit, swb_bit;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pm_clkdiv_top #(.DIV_WIDTH(8), .NUM_SERIAL(NS), .NUM_EXTINT(NE)) u_dut (
    .clk(clk), .rst(rst),
    .wr_mode_en(wr_mode_en), .wr_mode_val(wr_mode_val),
    .wr_swb_en(wr_swb_en), .wr_swb_val(wr_swb_val),
    .serial_busy(serial_busy), .extint_pend(extint_pend),
    .sys_ce(sys_ce), .mode_bit(mode_bit), .swb_bit(swb_bit)
  );

  // Behavioural reference model, advanced on each rising edge.
  int m_mode = 0, m_swb = 0, m_ce = 1, m_ticks = 0;
  logic [NS-1:0] m_pbusy = '0;
  logic [NE-1:0] m_ppend = '0;
  bit started = 0;

  always @(posedge clk) begin
    int nmode;
    bit active, wake;
    started = 1;
    if (rst) begin
      m_mode = 0; m_swb = 0; m_ce = 1; m_ticks = 0;
      m_pbusy = '0; m_ppend = '0;
    end else begin
      active = (serial_busy != 0) || (extint_pend != 0);
      wake = ((serial_busy & ~m_pbusy) != 0) || ((extint_pend & ~m_ppend) != 0);
      nmode = m_mode;
      if (wr_mode_en) begin
        if (!wr_mode_val) nmode = 0;
        else if (!active) nmode = 1;
      end
      if (m_swb == 1 && m_mode == 1 && wake) nmode = 0;
      if (nmode == 0) begin
        m_ce = 1; m_ticks = 0;
      end else if (m_mode == 0) begin
        m_ce = 0; m_ticks = 0;
      end else begin
        m_ticks = m_ticks + 1;
        m_ce = (m_ticks % PERIOD == 0) ? 1 : 0;
      end
      m_mode = nmode;
      if (wr_swb_en) m_swb = wr_swb_val ? 1 : 0;
      m_pbusy = serial_busy;
      m_ppend = extint_pend;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model on the falling edge.
  always @(negedge clk) begin
    if (started) begin
      check(sys_ce === m_ce[0], "R1 R2 R3 sys_ce vs model", int'(sys_ce), m_ce);
      check(mode_bit === m_mode[0], "R4 mode_bit vs model", int'(mode_bit), m_mode);
      check(swb_bit === m_swb[0], "R8 swb_bit vs model", int'(swb_bit), m_swb);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic v);
    wr_mode_en = 1'b1; wr_mode_val = v;
    tick(1);
    wr_mode_en = 1'b0; wr_mode_val = 1'b0;
  endtask

  task automatic write_swb(input logic v);
    wr_swb_en = 1'b1; wr_swb_val = v;
    tick(1);
    wr_swb_en = 1'b0; wr_swb_val = 1'b0;
  endtask

  // Counts cycles from now until sys_ce reads 1.
  task automatic cycles_to_ce(output int j);
    j = 0;
    while (!sys_ce && j < 1000) begin
      tick(1);
      j++;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int j, hits;
    tick(2);
    check(!mode_bit && !swb_bit && sys_ce, "R9 state in reset",
          int'({mode_bit, swb_bit, sys_ce}), 1);
    rst = 1'b0;
    tick(1);
    check(!mode_bit && !swb_bit && sys_ce, "R9 state after reset",
          int'({mode_bit, swb_bit, sys_ce}), 1);

    // R1 full rate
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      if (sys_ce) hits++;
      tick(1);
    end
    check(hits == 20, "R1 full-rate enables", hits, 20);

    // R2 entry and spacing
    write_mode(1'b1);
    check(mode_bit == 1'b1, "R4 mode set by write", int'(mode_bit), 1);
    cycles_to_ce(j);
    check(j == PERIOD, "R2 first slow pulse delay", j, PERIOD);
    tick(1);
    check(!sys_ce, "R2 pulse lasts one cycle", int'(sys_ce), 0);
    cycles_to_ce(j);
    check(j + 1 == PERIOD, "R2 pulse period", j + 1, PERIOD);

    // R4 rewrite of 1 does not restart spacing
    j = 0;
    repeat (100) begin tick(1); j++; end
    write_mode(1'b1);
    j++;
    while (!sys_ce && j < 1000) begin tick(1); j++; end
    check(j == PERIOD, "R4 rewrite keeps spacing", j, PERIOD);

    // R3 exit
    tick(37);
    write_mode(1'b0);
    check(!mode_bit && sys_ce, "R3 immediate full rate on exit",
          int'({mode_bit, sys_ce}), 1);

    // R5 guard on serial activity
    serial_busy = 2'b01;
    tick(1);
    write_mode(1'b1);
    check(!mode_bit && sys_ce, "R5 set ignored while serial busy",
          int'({mode_bit, sys_ce}), 1);
    serial_busy = '0;
    tick(2);

    // R6 guard on pending interrupt
    extint_pend = 4'b0100;
    tick(1);
    write_mode(1'b1);
    check(!mode_bit && sys_ce, "R6 set ignored while interrupt pending",
          int'({mode_bit, sys_ce}), 1);
    extint_pend = '0;
    tick(2);

    // R7 / R8 switchback on interrupt
    write_swb(1'b1);
    check(swb_bit == 1'b1, "R8 swb set by write", int'(swb_bit), 1);
    write_mode(1'b1);
    tick(50);
    extint_pend = 4'b0010;
    tick(1);
    check(!mode_bit, "R7 switchback on interrupt", int'(mode_bit), 0);
    check(sys_ce, "R3 full rate after switchback", int'(sys_ce), 1);
    check(swb_bit, "R8 swb kept after switchback", int'(swb_bit), 1);
    extint_pend = '0;
    tick(2);

    // R7 switchback on serial start
    write_mode(1'b1);
    tick(10);
    serial_busy = 2'b10;
    tick(1);
    check(!mode_bit, "R7 switchback on serial start", int'(mode_bit), 0);
    serial_busy = '0;
    tick(2);

    // R7 no switchback when disabled
    write_swb(1'b0);
    check(!swb_bit, "R8 swb cleared by write", int'(swb_bit), 0);
    write_mode(1'b1);
    tick(5);
    extint_pend = 4'b1000;
    tick(3);
    check(mode_bit, "R7 mode held with switchback off", int'(mode_bit), 1);
    write_mode(1'b0);
    extint_pend = '0;
    tick(2);

    // R9 reset during low-power mode
    write_swb(1'b1);
    write_mode(1'b1);
    tick(20);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(1);
    check(!mode_bit && !swb_bit && sys_ce, "R9 reset clears mode",
          int'({mode_bit, swb_bit, sys_ce}), 1);
    tick(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule